// File: doc/BRIEF.md
# Tagged-Write Histogram Bin Updater

This block keeps one 256-bin sub-histogram per warp in a local store and applies a batch of up to 32 bin increments, one per lane, presented together in a single cycle. No atomic read-modify-write is available. Each lane reads its bin, adds one to the count, and writes the word back with its own lane number in the upper bits. The store accepts only one of several writes aimed at the same word in a cycle. In the next cycle each lane reads its bin again. A lane whose word came back exactly as it wrote it has committed. Any other lane tries again in the next round. When no lane is left pending, the block raises a one-cycle done pulse and reports how many rounds the batch took.

A second operation combines the per-warp sub-histograms into one work-group histogram. It walks the bins one per cycle, adds the count fields of every warp, and writes untagged totals. A combinational read port shows any word of any sub-histogram or of the combined histogram.

Top module: `tagged_hist_updater`

## Requirements
- R1: Each stored word is WORD_W bits: the top TAG_W bits (bits 31:27 by default) hold the lane number of the last writer, and the low CNT_W = WORD_W-TAG_W bits (bits 26:0) hold the count. Every word reads as zero after reset.
- R2: After a batch, the count of every bin has grown by exactly the number of valid lanes that named it.
- R3: When several pending lanes write the same bin in one round, the write of the highest-numbered lane lands. After a batch, the tag of each touched bin is therefore the lowest-numbered valid lane that named it.
- R4: The `rounds` output, valid from the done pulse until the next start, equals the largest number of valid lanes naming one bin. It is 32 when all 32 lanes name the same bin.
- R5: A start seen while idle with r > 0 valid rounds needed holds `busy` high for 2r cycles, starting the cycle after start. `done` pulses for one cycle when `busy` falls. With no valid lane, `done` pulses the cycle after start, `busy` stays low, and `rounds` is 0.
- R6: Lanes with `lane_valid` low change no word, including the bins they present.
- R7: `start` and `merge_start` have no effect while `busy` is high. If both are raised in the same idle cycle, `start` wins.
- R8: `warp_sel`, captured at start, selects the sub-histogram that a batch updates. The other sub-histograms stay unchanged.
- R9: A count at 2^CNT_W-1 stays there when incremented and never carries into the tag bits.
- R10: A merge started while idle writes bin b of the combined histogram with the saturated sum of the count fields of bin b across all warps, with the tag bits zero. `busy` is high for BINS cycles and `merge_done` pulses when it falls. The sub-histograms are left unchanged.
- R11: `rd_data` shows, in the same cycle, the combined-histogram word `rd_bin` when `rd_group` is 1, or otherwise the word `rd_bin` of sub-histogram `rd_warp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a batch (sampled when idle) |
| warp_sel | input | WARP_W | Sub-histogram to update |
| lane_valid | input | LANES | Per-lane request valid |
| lane_bin | input | LANES*BIN_W | Per-lane bin index, lane l at bits l*BIN_W upward |
| merge_start | input | 1 | Begin combining sub-histograms (sampled when idle) |
| rd_group | input | 1 | Read port selects the combined histogram |
| rd_warp | input | WARP_W | Read port sub-histogram select |
| rd_bin | input | BIN_W | Read port bin index |
| rd_data | output | WORD_W | Read port data |
| busy | output | 1 | Batch or merge in progress |
| done | output | 1 | One-cycle pulse at batch end |
| rounds | output | RND_W | Rounds used by the last batch |
| merge_done | output | 1 | One-cycle pulse at merge end |

## Verification
The hardest situation to reach from the ports is a round in which winners and losers mix at the same time: some bins are contested by many lanes while others have a single lane, and lanes drop out in different rounds. The stimulus reaches it with lane patterns drawn from a small pool of bins, so conflicts of uneven depth occur. It adds fixed patterns for the all-lanes-on-one-bin worst case and for even lanes sharing one bin. A second, narrow-word instance driven by the same inputs reaches count saturation in a single batch. A start and a merge request raised in the middle of a busy batch check that nothing is disturbed.

// File: rtl/hist_pkg.sv
// Package: shared state encoding for the tagged-write histogram updater.
// Assumes: used by tagged_hist_updater only.
package hist_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_VERIFY = 2'd2,
        ST_MERGE  = 2'd3
    } upd_state_e;
endpackage

// File: rtl/hist_lane_incr.sv
// Module: hist_lane_incr
// Builds the word one lane proposes to write: its fixed lane tag above the
// stored count plus one, with the count held at its maximum instead of wrapping.
// Assumes: LANE_ID < 2**TAG_W.
module hist_lane_incr #(
    parameter int WORD_W  = 32,
    parameter int TAG_W   = 5,
    parameter int LANE_ID = 0
) (
    input  logic [WORD_W-1:0] stored,
    output logic [WORD_W-1:0] proposed
);
    localparam int CNT_W = WORD_W - TAG_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [TAG_W-1:0] TAG = TAG_W'(LANE_ID);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;

    // Strip the old tag, saturate-increment the count, attach this lane's tag.
    always_comb begin
        cnt      = stored[CNT_W-1:0];
        cnt_next = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);
        proposed = {TAG, cnt_next};
    end
endmodule

// File: rtl/hist_commit_track.sv
// Module: hist_commit_track
// Holds each lane's pending flag and the word it last wrote. On a check it
// clears the flags of lanes whose read-back word equals what they wrote.
// Assumes: capture and check are never high in the same cycle.
module hist_commit_track #(
    parameter int LANES  = 32,
    parameter int WORD_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [LANES-1:0]              load_mask,
    input  logic                          capture,
    input  logic                          check,
    input  logic [LANES-1:0][WORD_W-1:0]  proposed,
    input  logic [LANES-1:0][WORD_W-1:0]  readback,
    output logic [LANES-1:0]              pending_q,
    output logic                          settled
);
    logic [LANES-1:0][WORD_W-1:0] written_q;
    logic [LANES-1:0]             hit;

    // Per-lane comparison of the read-back word against the lane's own write.
    for (genvar l = 0; l < LANES; l++) begin : g_cmp
        assign hit[l] = (readback[l] == written_q[l]);
    end

    // After this check, no lane is left pending.
    assign settled = ((pending_q & ~hit) == '0);

    // Pending flags: loaded at start, cleared for lanes whose write stuck.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else if (load) begin
            pending_q <= load_mask;
        end else if (check) begin
            pending_q <= pending_q & ~hit;
        end
    end

    // Remember what every lane attempted to write this round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written_q <= '0;
        end else if (capture) begin
            written_q <= proposed;
        end
    end
endmodule

// File: rtl/hist_merge_sum.sv
// Module: hist_merge_sum
// Adds the count fields of one bin across all warps, saturates the sum to the
// count width and returns it with the tag bits cleared.
// Assumes: NUM_WARPS >= 1.
module hist_merge_sum #(
    parameter int NUM_WARPS = 2,
    parameter int WORD_W    = 32,
    parameter int TAG_W     = 5
) (
    input  logic [NUM_WARPS-1:0][WORD_W-1:0] words,
    output logic [WORD_W-1:0]                total
);
    localparam int CNT_W = WORD_W - TAG_W;
    localparam int ACC_W = CNT_W + $clog2(NUM_WARPS) + 1;
    localparam logic [ACC_W-1:0] ACC_LIM = {{(ACC_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [ACC_W-1:0] acc;

    // Sum the counts of every warp, ignoring tags, then clamp and untag.
    always_comb begin
        acc = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            acc = acc + ACC_W'(words[w][CNT_W-1:0]);
        end
        total = {{TAG_W{1'b0}}, (acc > ACC_LIM) ? ACC_LIM[CNT_W-1:0] : acc[CNT_W-1:0]};
    end
endmodule

// File: rtl/tagged_hist_updater.sv
// Module: tagged_hist_updater (top)
// Per-warp sub-histograms updated by a tag-and-verify retry loop over a store
// in which, among same-bin writes in one cycle, the highest lane wins. Also
// holds the combined histogram filled by a sequential merge pass.
// Assumes: LANES <= 2**TAG_W; requests arrive only through start while idle.
module tagged_hist_updater
    import hist_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int BINS      = 256,
    parameter int NUM_WARPS = 2,
    parameter int WORD_W    = 32,
    parameter int TAG_W     = 5,
    localparam int BIN_W    = $clog2(BINS),
    localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int RND_W    = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [WARP_W-1:0]        warp_sel,
    input  logic [LANES-1:0]         lane_valid,
    input  logic [LANES*BIN_W-1:0]   lane_bin,
    input  logic                     merge_start,
    input  logic                     rd_group,
    input  logic [WARP_W-1:0]        rd_warp,
    input  logic [BIN_W-1:0]         rd_bin,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     busy,
    output logic                     done,
    output logic [RND_W-1:0]         rounds,
    output logic                     merge_done
);
    upd_state_e                    state_q;
    logic [WARP_W-1:0]             warp_q;
    logic [LANES-1:0][BIN_W-1:0]   bin_q;
    logic [BIN_W-1:0]              mrg_idx_q;
    logic [RND_W-1:0]              rounds_q;
    logic                          done_q;
    logic                          merge_done_q;

    logic [WORD_W-1:0]             sub_mem [NUM_WARPS][BINS];
    logic [WORD_W-1:0]             grp_mem [BINS];

    logic [LANES-1:0][WORD_W-1:0]  lane_stored;
    logic [LANES-1:0][WORD_W-1:0]  lane_prop;
    logic [LANES-1:0]              pending_q;
    logic                          settled;
    logic [NUM_WARPS-1:0][WORD_W-1:0] mrg_in;
    logic [WORD_W-1:0]             mrg_word;
    logic                          accept_batch;

    assign accept_batch = (state_q == ST_IDLE) && start;

    // Each lane sees its bin's current word and forms its tagged increment.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_stored[l] = sub_mem[warp_q][bin_q[l]];
        hist_lane_incr #(
            .WORD_W (WORD_W),
            .TAG_W  (TAG_W),
            .LANE_ID(l)
        ) u_incr (
            .stored  (lane_stored[l]),
            .proposed(lane_prop[l])
        );
    end

    hist_commit_track #(
        .LANES (LANES),
        .WORD_W(WORD_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_batch),
        .load_mask(lane_valid),
        .capture  (state_q == ST_WRITE),
        .check    (state_q == ST_VERIFY),
        .proposed (lane_prop),
        .readback (lane_stored),
        .pending_q(pending_q),
        .settled  (settled)
    );

    // Gather one bin from every warp for the merge pass.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_mrg
        assign mrg_in[w] = sub_mem[w][mrg_idx_q];
    end

    hist_merge_sum #(
        .NUM_WARPS(NUM_WARPS),
        .WORD_W   (WORD_W),
        .TAG_W    (TAG_W)
    ) u_merge (
        .words(mrg_in),
        .total(mrg_word)
    );

    // Sequencer: idle, write/verify rounds of a batch, or the merge walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            warp_q       <= '0;
            bin_q        <= '0;
            mrg_idx_q    <= '0;
            rounds_q     <= '0;
            done_q       <= 1'b0;
            merge_done_q <= 1'b0;
        end else begin
            done_q       <= 1'b0;
            merge_done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        warp_q   <= warp_sel;
                        bin_q    <= lane_bin;
                        rounds_q <= '0;
                        if (lane_valid == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_WRITE;
                        end
                    end else if (merge_start) begin
                        mrg_idx_q <= '0;
                        state_q   <= ST_MERGE;
                    end
                end
                ST_WRITE: begin
                    rounds_q <= rounds_q + RND_W'(1);
                    state_q  <= ST_VERIFY;
                end
                ST_VERIFY: begin
                    if (settled) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_WRITE;
                    end
                end
                ST_MERGE: begin
                    mrg_idx_q <= mrg_idx_q + BIN_W'(1);
                    if (mrg_idx_q == BIN_W'(BINS - 1)) begin
                        merge_done_q <= 1'b1;
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sub-histogram store: later (higher) lanes overwrite earlier ones on a clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WARPS; w++) begin
                for (int b = 0; b < BINS; b++) begin
                    sub_mem[w][b] <= '0;
                end
            end
        end else if (state_q == ST_WRITE) begin
            for (int l = 0; l < LANES; l++) begin
                if (pending_q[l]) begin
                    sub_mem[warp_q][bin_q[l]] <= lane_prop[l];
                end
            end
        end
    end

    // Combined histogram store: one untagged bin per merge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BINS; b++) begin
                grp_mem[b] <= '0;
            end
        end else if (state_q == ST_MERGE) begin
            grp_mem[mrg_idx_q] <= mrg_word;
        end
    end

    // Output mapping and the combinational read port.
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign merge_done = merge_done_q;
    assign rounds     = rounds_q;
    assign rd_data    = rd_group ? grp_mem[rd_bin] : sub_mem[rd_warp][rd_bin];
endmodule

// File: rtl/tagged_hist_updater_chk.sv
// Module: tagged_hist_updater_chk
// Property checker for tagged_hist_updater, attached by the bind below.
// Assumes: connected to the top's ports and its pending-lane vector.
module tagged_hist_updater_chk #(
    parameter int LANES  = 32,
    parameter int WORD_W = 32,
    parameter int TAG_W  = 5,
    localparam int RND_W = $clog2(LANES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              merge_done,
    input logic [RND_W-1:0]  rounds,
    input logic              rd_group,
    input logic [WORD_W-1:0] rd_data,
    input logic [LANES-1:0]  pending
);
    // R5: done is a single-cycle pulse.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done is raised only once the block has gone idle.
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: no batch ever needs more rounds than there are lanes.
    assert_rounds_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rounds <= RND_W'(LANES)));

    // R2: inside a run a lane may leave the pending set but never re-enter it.
    assert_pending_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((pending & ~$past(pending)) == '0));

    // R10: combined-histogram words never carry tag bits.
    assert_group_untagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_group |-> (rd_data[WORD_W-1 -: TAG_W] == '0));

    // R10: merge_done is a single-cycle pulse taken while idle.
    assert_merge_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        merge_done |-> (!busy && !$past(merge_done)));
endmodule

bind tagged_hist_updater tagged_hist_updater_chk #(
    .LANES (LANES),
    .WORD_W(WORD_W),
    .TAG_W (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .merge_done(merge_done),
    .rounds    (rounds),
    .rd_group  (rd_group),
    .rd_data   (rd_data),
    .pending   (pending_q)
);

// File: tb/test_tagged_hist_updater.sv
`timescale 1ns/1ps
// Bench: behavioural model (per-bin counts and tags, rounds from lane
// multiplicities) compared every clock against a 32-bit instance and a narrow
// 8-bit instance (3-bit count) fed the same stimulus.
module test_tagged_hist_updater;
    localparam int LANES = 32;
    localparam int BINS  = 256;
    localparam int BIN_W = 8;
    localparam int MAIN_LIM = (1 << 27) - 1;
    localparam int NAR_LIM  = 7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                   rst_n, start, merge_start, rd_group;
    logic [0:0]             warp_sel, rd_warp;
    logic [LANES-1:0]       lane_valid;
    logic [LANES*BIN_W-1:0] lane_bin;
    logic [BIN_W-1:0]       rd_bin;
    logic [31:0]            rd_data;
    logic [7:0]             n_rd_data;
    logic                   busy, done, merge_done, n_busy, n_done, n_merge_done;
    logic [5:0]             rounds, n_rounds;

    tagged_hist_updater i_tagged_hist_updater (
        .clk(clk), .rst_n(rst_n), .start(start), .warp_sel(warp_sel),
        .lane_valid(lane_valid), .lane_bin(lane_bin), .merge_start(merge_start),
        .rd_group(rd_group), .rd_warp(rd_warp), .rd_bin(rd_bin), .rd_data(rd_data),
        .busy(busy), .done(done), .rounds(rounds), .merge_done(merge_done));

    tagged_hist_updater #(.WORD_W(8), .TAG_W(5)) i_tagged_hist_updater_narrow (
        .clk(clk), .rst_n(rst_n), .start(start), .warp_sel(warp_sel),
        .lane_valid(lane_valid), .lane_bin(lane_bin), .merge_start(merge_start),
        .rd_group(rd_group), .rd_warp(rd_warp), .rd_bin(rd_bin), .rd_data(n_rd_data),
        .busy(n_busy), .done(n_done), .rounds(n_rounds), .merge_done(n_merge_done));

    int vectors = 0;
    int miscompares = 0;
    int mcnt [2][BINS];
    int mtag [2][BINS];
    int ncnt [2][BINS];
    int gcnt [BINS];
    int ngcnt[BINS];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R11/R1: read one bin of a sub-histogram from both instances.
    task automatic check_bin(input string req, input int w, input int b);
        @(negedge clk);
        rd_group = 1'b0; rd_warp = w[0:0]; rd_bin = b[7:0];
        #1;
        chk(req, rd_data, (32'(mtag[w][b]) << 27) | 32'(mcnt[w][b]));
        chk(req, {24'd0, n_rd_data}, (32'(mtag[w][b]) << 3) | 32'(ncnt[w][b]));
    endtask

    // Apply one batch and compare busy/done on every clock until done.
    task automatic run_batch(input int w, input logic [LANES-1:0] vmask,
                             input int lb[LANES], input bit disturb);
        int mult[BINS];
        int low[BINS];
        int r;
        r = 0;
        for (int b = 0; b < BINS; b++) begin mult[b] = 0; low[b] = -1; end
        for (int l = 0; l < LANES; l++) begin
            if (vmask[l]) begin
                mult[lb[l]]++;
                if (low[lb[l]] < 0) low[lb[l]] = l;
                if (mult[lb[l]] > r) r = mult[lb[l]];
            end
        end
        @(negedge clk);
        start = 1'b1; warp_sel = w[0:0]; lane_valid = vmask;
        for (int l = 0; l < LANES; l++) lane_bin[l*BIN_W +: BIN_W] = lb[l][7:0];
        for (int k = 0; k <= 2 * r; k++) begin
            @(negedge clk);
            if (k == 0) begin
                start = disturb; merge_start = disturb;
                if (disturb) begin lane_valid = '1; lane_bin = '0; warp_sel = ~warp_sel; end
            end else if (k == 1) begin
                start = 1'b0; merge_start = 1'b0;
            end
            chk("R5 busy", {31'd0, busy}, {31'd0, (r > 0 && k < 2 * r)});
            chk("R5 done", {31'd0, done}, {31'd0, (k == 2 * r)});
            chk("R5 narrow busy", {31'd0, n_busy}, {31'd0, (r > 0 && k < 2 * r)});
            chk("R5 narrow done", {31'd0, n_done}, {31'd0, (k == 2 * r)});
        end
        start = 1'b0; merge_start = 1'b0;
        chk("R4 rounds", {26'd0, rounds}, 32'(r));
        chk("R4 narrow rounds", {26'd0, n_rounds}, 32'(r));
        for (int b = 0; b < BINS; b++) begin
            if (mult[b] > 0) begin
                mcnt[w][b] = (mcnt[w][b] + mult[b] > MAIN_LIM) ? MAIN_LIM : mcnt[w][b] + mult[b];
                ncnt[w][b] = (ncnt[w][b] + mult[b] > NAR_LIM) ? NAR_LIM : ncnt[w][b] + mult[b];
                mtag[w][b] = low[b];
            end
        end
        for (int l = 0; l < LANES; l++) check_bin("R2 R3 bin after batch", w, lb[l]);
    endtask

    int lb[LANES];
    bit wd_fired = 1'b0;

    initial begin
        #(200000 * 5);
        wd_fired = 1'b1;
        miscompares++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int w = 0; w < 2; w++)
            for (int b = 0; b < BINS; b++) begin
                mcnt[w][b] = 0; mtag[w][b] = 0; ncnt[w][b] = 0;
            end
        rst_n = 1'b0; start = 1'b0; merge_start = 1'b0; rd_group = 1'b0;
        warp_sel = '0; rd_warp = '0; rd_bin = '0; lane_valid = '0; lane_bin = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset done", {31'd0, done}, 32'd0);
        chk("R1 reset merge_done", {31'd0, merge_done}, 32'd0);
        check_bin("R1 reset word", 0, 0);
        check_bin("R1 reset word", 1, 255);

        // R2: all distinct bins, one round
        for (int l = 0; l < LANES; l++) lb[l] = l * 3;
        run_batch(0, '1, lb, 1'b0);

        // R4 R3: all 32 lanes on one bin, worst case 32 rounds
        for (int l = 0; l < LANES; l++) lb[l] = 200;
        run_batch(0, '1, lb, 1'b0);
        // R9: narrow instance count saturates at 7, tag of lane 0
        check_bin("R9 saturation", 0, 200);

        // R3: even lanes share bin 5, odd lanes distinct bins -> 16 rounds
        for (int l = 0; l < LANES; l++) lb[l] = (l % 2 == 0) ? 5 : 100 + l;
        run_batch(0, '1, lb, 1'b0);

        // R6: invalid lanes name bins 240..255 which must stay untouched
        for (int l = 0; l < LANES; l++) lb[l] = (l < 16) ? 60 + (l % 4) : 224 + l;
        run_batch(0, 32'h0000_FFFF, lb, 1'b0);
        for (int l = 16; l < LANES; l++) check_bin("R6 invalid lane bin", 0, 224 + l);

        // R5: no valid lane, done next cycle with zero rounds
        run_batch(0, '0, lb, 1'b0);

        // R8 R7: warp 1 batch with start/merge_start raised mid-run
        for (int l = 0; l < LANES; l++) lb[l] = 10 + (l % 5);
        run_batch(1, '1, lb, 1'b1);
        check_bin("R8 other warp untouched", 0, 10);
        check_bin("R8 other warp untouched", 0, 200);

        // R2 R3: pseudo-random patterns with uneven conflicts
        for (int t = 0; t < 8; t++) begin
            for (int l = 0; l < LANES; l++) lb[l] = 32 + $urandom_range(0, 11);
            run_batch(t % 2, 32'($urandom()) | 32'h1, lb, 1'b0);
        end

        // R10: merge pass
        for (int b = 0; b < BINS; b++) begin
            gcnt[b]  = (mcnt[0][b] + mcnt[1][b] > MAIN_LIM) ? MAIN_LIM : mcnt[0][b] + mcnt[1][b];
            ngcnt[b] = (ncnt[0][b] + ncnt[1][b] > NAR_LIM) ? NAR_LIM : ncnt[0][b] + ncnt[1][b];
        end
        @(negedge clk);
        merge_start = 1'b1;
        for (int k = 0; k <= BINS; k++) begin
            @(negedge clk);
            merge_start = 1'b0;
            chk("R10 merge busy", {31'd0, busy}, {31'd0, (k < BINS)});
            chk("R10 merge_done", {31'd0, merge_done}, {31'd0, (k == BINS)});
        end
        for (int b = 0; b < BINS; b++) begin
            @(negedge clk);
            rd_group = 1'b1; rd_bin = b[7:0];
            #1;
            chk("R10 merged word", rd_data, 32'(gcnt[b]));
            chk("R10 narrow merged word", {24'd0, n_rd_data}, 32'(ngcnt[b]));
        end
        rd_group = 1'b0;
        check_bin("R10 sub-histogram unchanged", 0, 200);
        check_bin("R10 sub-histogram unchanged", 1, 12);

        if (!wd_fired) begin
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule